// File: doc/BRIEF.md
# Decoded Sector Buffer Writer

This block takes each sector that the drive side delivers as a byte stream and decides what to do with it. A sector is a 4-byte header followed by 2048 data bytes, 2052 bytes in all. The first byte carries a start-of-sector marker. Bytes arrive one per cycle at most, through a valid/ready handshake. The decode-enable and write-enable controls are sampled when the first byte is accepted.

With decoding off, the sector is consumed and dropped, and the drive side is told to repeat the same sector. With decoding on, the header is latched into the visible header bank once its fourth byte arrives. Status3 then reads 0x00, meaning valid, and the active-low decoder-pending flag goes low. An interrupt level follows that flag when decoder interrupts are enabled.

If writing is also on, the block pointer and the write address each advance by one raw sector of 2352 bytes as the sector starts. The 2052 stored bytes then go to a circular 16 KiB buffer RAM. They start at the new block pointer masked to 14 bits and wrap past 0x3FFF to address 0. After the last byte a one-cycle done pulse appears together with either next-sector or same-sector.

The sequencer has four states. SW_IDLE goes to SW_HEAD on a marked byte. SW_HEAD goes to SW_BODY on the fourth header byte. SW_BODY goes to SW_FIN on the 2052nd byte. SW_FIN goes back to SW_IDLE after one cycle.

Top module: `sector_buf_writer`

## Requirements
- R1: After reset, blk_ptr and wr_addr are 0x0000, status3 is 0x80, dec_pend_n is 1, irq is 0, done is 0, s_ready is 1, and hdr_bank is 0x01000000, with header byte k held at bits [8k+7:8k].
- R2: A sector that starts while dec_en is 0 stores nothing and leaves the header bank, status3, dec_pend_n, blk_ptr and wr_addr unchanged.
- R3: A sector that starts with dec_en 1 loads its 4 header bytes into hdr_bank, byte k at bits [8k+7:8k], and sets status3 to 0x00 and dec_pend_n to 0.
- R4: irq equals dec_irq_en AND NOT dec_pend_n at all times, as a level.
- R5: A sector that starts with both dec_en and wr_en at 1 adds 2352, modulo 65536, to blk_ptr and to wr_addr.
- R6: In a storing sector, byte k of the 2052 (header bytes 0-3 first, then data) is written with mem_we to address (new blk_ptr + k) mod 16384. A sector crossing 0x3FFF wraps to address 0.
- R7: One cycle after the 2052nd byte is accepted, done is high for exactly one cycle. In that cycle next_sec is 1 if the sector was stored, and same_sec is 1 otherwise.
- R8: A pulse on st3_rd sets status3 to 0x80 and dec_pend_n to 1 in the next cycle. A pulse during a store does not disturb the store.
- R9: s_ready is low only in the done cycle. Bytes offered in idle without s_sof are accepted and dropped. An s_sof flag on a byte inside a sector is treated as ordinary data.
- R10: dec_en and wr_en are sampled only on the first byte of a sector. Changing them mid-sector does not alter that sector's storing, header latch or done outcome.
- R11: ptr_ld and wa_ld load ld_data into blk_ptr and wr_addr, visible one cycle later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| dec_en | input | 1 | Decode enable, sampled at sector start |
| wr_en | input | 1 | Buffer write enable, sampled at sector start |
| dec_irq_en | input | 1 | Decoder interrupt enable |
| s_valid | input | 1 | Stream byte valid |
| s_sof | input | 1 | First byte of a sector |
| s_data | input | 8 | Stream byte |
| s_ready | output | 1 | Stream byte accepted when high with s_valid |
| ptr_ld | input | 1 | Load block pointer from ld_data |
| wa_ld | input | 1 | Load write address from ld_data |
| ld_data | input | 16 | Host load value |
| st3_rd | input | 1 | Host read of status3, clears valid and pending |
| mem_we | output | 1 | Buffer RAM write strobe |
| mem_addr | output | 14 | Buffer RAM byte address |
| mem_wdata | output | 8 | Buffer RAM write byte |
| hdr_bank | output | 32 | Latched header, byte k at bits [8k+7:8k] |
| status3 | output | 8 | 0x00 after a decode, 0x80 otherwise |
| dec_pend_n | output | 1 | Decoder pending, active low |
| irq | output | 1 | Decoder interrupt level |
| blk_ptr | output | 16 | Block pointer |
| wr_addr | output | 16 | Write address |
| done | output | 1 | One-cycle end-of-sector pulse |
| next_sec | output | 1 | With done: advance to next sector |
| same_sec | output | 1 | With done: repeat the same sector |

## Verification
Each enable combination is tried with a full sector whose bytes are a function of sector number and position. This separates a discarded sector, a header-only decode and a full store. Stores are run from block-pointer start values placed at the buffer start, in the middle, straddling 0x3FFF and overflowing 16 bits. These distinguish a correct modulo-16384 wrap from a clipped or unwrapped address, and a 2352 step from a 2052 step. Sectors with mid-stream enable flips, a status3 read and a stray start marker show that only the first byte's sampling matters. Bytes offered while idle without a marker show that no write or pointer change comes from noise.

// File: rtl/sbw_pkg.sv
package sbw_pkg;

    typedef enum logic [1:0] {
        SW_IDLE = 2'd0,
        SW_HEAD = 2'd1,
        SW_BODY = 2'd2,
        SW_FIN  = 2'd3
    } sbw_state_e;

    localparam logic [7:0] ST3_EMPTY = 8'h80;
    localparam logic [7:0] ST3_VALID = 8'h00;
    localparam logic [7:0] HDR_LAST_RST = 8'h01;

endpackage

// File: rtl/sbw_seq.sv
module sbw_seq
    import sbw_pkg::*;
#(
    parameter int HDR_BYTES  = 4,
    parameter int DATA_BYTES = 2048,
    localparam int TOTAL = HDR_BYTES + DATA_BYTES,
    localparam int CNT_W = $clog2(TOTAL + 1),
    localparam int HI_W  = $clog2(HDR_BYTES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             s_valid,
    input  logic             s_sof,
    input  logic             dec_en,
    input  logic             wr_en,
    output logic             s_ready,
    output logic             start,
    output logic             store,
    output logic             hdr_we,
    output logic [HI_W-1:0]  hdr_idx,
    output logic             hdr_commit,
    output logic             done,
    output logic             next_sec,
    output logic             same_sec,
    output logic [CNT_W-1:0] offset
);

    sbw_state_e state, state_nx;
    logic [CNT_W-1:0] cnt, cnt_nx;
    logic dec_q, wr_q, dec_nx, wr_nx;
    logic take;

    assign s_ready = (state != SW_FIN);
    assign take    = s_valid & s_ready;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= SW_IDLE;
            cnt   <= '0;
            dec_q <= 1'b0;
            wr_q  <= 1'b0;
        end else begin
            state <= state_nx;
            cnt   <= cnt_nx;
            dec_q <= dec_nx;
            wr_q  <= wr_nx;
        end
    end

    always_comb begin
        state_nx = state;
        cnt_nx   = cnt;
        dec_nx   = dec_q;
        wr_nx    = wr_q;
        unique case (state)
            SW_IDLE: begin
                if (take && s_sof) begin
                    state_nx = SW_HEAD;
                    cnt_nx   = CNT_W'(1);
                    dec_nx   = dec_en;
                    wr_nx    = dec_en & wr_en;
                end
            end
            SW_HEAD: begin
                if (take) begin
                    cnt_nx = cnt + 1'b1;
                    if (cnt == CNT_W'(HDR_BYTES - 1))
                        state_nx = SW_BODY;
                end
            end
            SW_BODY: begin
                if (take) begin
                    cnt_nx = cnt + 1'b1;
                    if (cnt == CNT_W'(TOTAL - 1))
                        state_nx = SW_FIN;
                end
            end
            SW_FIN: begin
                state_nx = SW_IDLE;
                cnt_nx   = '0;
            end
            default: state_nx = SW_IDLE;
        endcase
    end

    always_comb begin
        start      = 1'b0;
        store      = 1'b0;
        hdr_we     = 1'b0;
        hdr_idx    = '0;
        hdr_commit = 1'b0;
        done       = 1'b0;
        next_sec   = 1'b0;
        same_sec   = 1'b0;
        offset     = '0;
        unique case (state)
            SW_IDLE: begin
                start  = take & s_sof;
                store  = take & s_sof & dec_en & wr_en;
                hdr_we = take & s_sof & dec_en;
            end
            SW_HEAD: begin
                store      = take & wr_q;
                hdr_we     = take & dec_q;
                hdr_idx    = cnt[HI_W-1:0];
                hdr_commit = take & dec_q & (cnt == CNT_W'(HDR_BYTES - 1));
                offset     = cnt;
            end
            SW_BODY: begin
                store  = take & wr_q;
                offset = cnt;
            end
            SW_FIN: begin
                done     = 1'b1;
                next_sec = wr_q;
                same_sec = ~wr_q;
            end
            default: ;
        endcase
    end

    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n) done |=> !done); // R7
    AST_DONE_ONE_ANSWER: assert property (@(posedge clk) disable iff (!rst_n) done |-> (next_sec ^ same_sec)); // R7
    AST_STALL_ONLY_AT_DONE: assert property (@(posedge clk) disable iff (!rst_n) !s_ready |-> done); // R9
    AST_RESUME_AFTER_DONE: assert property (@(posedge clk) disable iff (!rst_n) done |=> s_ready); // R9

endmodule

// File: rtl/sbw_hdr.sv
module sbw_hdr
    import sbw_pkg::*;
#(
    parameter int HDR_BYTES = 4,
    localparam int HI_W   = $clog2(HDR_BYTES),
    localparam int BANK_W = 8 * HDR_BYTES
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              hdr_we,
    input  logic [HI_W-1:0]   hdr_idx,
    input  logic [7:0]        din,
    input  logic              commit,
    input  logic              st3_rd,
    input  logic              irq_en,
    output logic [BANK_W-1:0] hdr_bank,
    output logic [7:0]        status3,
    output logic              dec_pend_n,
    output logic              irq
);

    for (genvar i = 0; i < HDR_BYTES; i++) begin : g_lane
        localparam logic [7:0] RST_V = (i == HDR_BYTES - 1) ? HDR_LAST_RST : 8'h00;
        localparam bit         LAST  = (i == HDR_BYTES - 1);
        logic [7:0] sh;
        logic [7:0] bk;
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                sh <= 8'h00;
                bk <= RST_V;
            end else begin
                if (hdr_we && hdr_idx == HI_W'(i))
                    sh <= din;
                if (commit)
                    bk <= LAST ? din : sh;
            end
        end
        assign hdr_bank[8*i +: 8] = bk;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            status3    <= ST3_EMPTY;
            dec_pend_n <= 1'b1;
        end else if (commit) begin
            status3    <= ST3_VALID;
            dec_pend_n <= 1'b0;
        end else if (st3_rd) begin
            status3    <= ST3_EMPTY;
            dec_pend_n <= 1'b1;
        end
    end

    assign irq = irq_en & ~dec_pend_n;

    AST_COMMIT_FLAGS: assert property (@(posedge clk) disable iff (!rst_n) commit |=> (status3 == ST3_VALID && !dec_pend_n)); // R3
    AST_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n) (st3_rd && !commit) |=> (status3 == ST3_EMPTY && dec_pend_n)); // R8
    AST_BANK_HOLDS: assert property (@(posedge clk) disable iff (!rst_n) !commit |=> $stable(hdr_bank)); // R2

endmodule

// File: rtl/sbw_addr.sv
module sbw_addr #(
    parameter int ADDR_W   = 14,
    parameter int PTR_W    = 16,
    parameter int RAW_STEP = 2352,
    parameter int OFF_W    = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [OFF_W-1:0]  off,
    input  logic              ptr_ld,
    input  logic              wa_ld,
    input  logic [PTR_W-1:0]  ld_data,
    output logic [PTR_W-1:0]  blk_ptr,
    output logic [PTR_W-1:0]  wr_addr,
    output logic [ADDR_W-1:0] mem_addr
);

    localparam logic [PTR_W-1:0] STEP = PTR_W'(RAW_STEP);

    logic [PTR_W-1:0]  nxt_ptr;
    logic [ADDR_W-1:0] base;

    assign nxt_ptr = blk_ptr + STEP;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            blk_ptr <= '0;
            wr_addr <= '0;
            base    <= '0;
        end else if (start) begin
            blk_ptr <= nxt_ptr;
            wr_addr <= wr_addr + STEP;
            base    <= nxt_ptr[ADDR_W-1:0];
        end else begin
            if (ptr_ld) blk_ptr <= ld_data;
            if (wa_ld)  wr_addr <= ld_data;
        end
    end

    assign mem_addr = start ? nxt_ptr[ADDR_W-1:0] : base + ADDR_W'(off);

    AST_PTR_STEP: assert property (@(posedge clk) disable iff (!rst_n) start |=> blk_ptr == $past(blk_ptr) + STEP); // R5
    AST_WA_STEP: assert property (@(posedge clk) disable iff (!rst_n) start |=> wr_addr == $past(wr_addr) + STEP); // R5

endmodule

// File: rtl/sector_buf_writer.sv
module sector_buf_writer #(
    parameter int HDR_BYTES  = 4,
    parameter int DATA_BYTES = 2048,
    parameter int ADDR_W     = 14,
    parameter int PTR_W      = 16,
    parameter int RAW_STEP   = 2352,
    localparam int TOTAL  = HDR_BYTES + DATA_BYTES,
    localparam int CNT_W  = $clog2(TOTAL + 1),
    localparam int HI_W   = $clog2(HDR_BYTES),
    localparam int BANK_W = 8 * HDR_BYTES
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              dec_en,
    input  logic              wr_en,
    input  logic              dec_irq_en,
    input  logic              s_valid,
    input  logic              s_sof,
    input  logic [7:0]        s_data,
    output logic              s_ready,
    input  logic              ptr_ld,
    input  logic              wa_ld,
    input  logic [PTR_W-1:0]  ld_data,
    input  logic              st3_rd,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [7:0]        mem_wdata,
    output logic [BANK_W-1:0] hdr_bank,
    output logic [7:0]        status3,
    output logic              dec_pend_n,
    output logic              irq,
    output logic [PTR_W-1:0]  blk_ptr,
    output logic [PTR_W-1:0]  wr_addr,
    output logic              done,
    output logic              next_sec,
    output logic              same_sec
);

    logic             start, hdr_we, hdr_commit;
    logic [HI_W-1:0]  hdr_idx;
    logic [CNT_W-1:0] offset;

    sbw_seq #(
        .HDR_BYTES (HDR_BYTES),
        .DATA_BYTES(DATA_BYTES)
    ) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .s_valid   (s_valid),
        .s_sof     (s_sof),
        .dec_en    (dec_en),
        .wr_en     (wr_en),
        .s_ready   (s_ready),
        .start     (start),
        .store     (mem_we),
        .hdr_we    (hdr_we),
        .hdr_idx   (hdr_idx),
        .hdr_commit(hdr_commit),
        .done      (done),
        .next_sec  (next_sec),
        .same_sec  (same_sec),
        .offset    (offset)
    );

    sbw_addr #(
        .ADDR_W  (ADDR_W),
        .PTR_W   (PTR_W),
        .RAW_STEP(RAW_STEP),
        .OFF_W   (CNT_W)
    ) u_addr (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (mem_we & start),
        .off     (offset),
        .ptr_ld  (ptr_ld),
        .wa_ld   (wa_ld),
        .ld_data (ld_data),
        .blk_ptr (blk_ptr),
        .wr_addr (wr_addr),
        .mem_addr(mem_addr)
    );

    sbw_hdr #(
        .HDR_BYTES(HDR_BYTES)
    ) u_hdr (
        .clk       (clk),
        .rst_n     (rst_n),
        .hdr_we    (hdr_we),
        .hdr_idx   (hdr_idx),
        .din       (s_data),
        .commit    (hdr_commit),
        .st3_rd    (st3_rd),
        .irq_en    (dec_irq_en),
        .hdr_bank  (hdr_bank),
        .status3   (status3),
        .dec_pend_n(dec_pend_n),
        .irq       (irq)
    );

    assign mem_wdata = s_data;

    AST_WE_NEEDS_HANDSHAKE: assert property (@(posedge clk) disable iff (!rst_n) mem_we |-> (s_valid && s_ready)); // R9
    AST_IRQ_LEVEL: assert property (@(posedge clk) disable iff (!rst_n) irq == (dec_irq_en && !dec_pend_n)); // R4
    AST_NO_STORE_UNDECODED: assert property (@(posedge clk) disable iff (!rst_n) (mem_we && start) |-> dec_en); // R2

endmodule

// File: tb/tb_sector_buf_writer.sv
module tb_sector_buf_writer;

    localparam int CLK_P = 10;
    localparam int Q     = CLK_P / 4;
    localparam int TOT   = 2052;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic dec_en = 0, wr_en = 0, dec_irq_en = 0;
    logic s_valid = 0, s_sof = 0;
    logic [7:0] s_data = 8'h00;
    logic s_ready;
    logic ptr_ld = 0, wa_ld = 0;
    logic [15:0] ld_data = 16'h0000;
    logic st3_rd = 0;
    logic mem_we;
    logic [13:0] mem_addr;
    logic [7:0] mem_wdata;
    logic [31:0] hdr_bank;
    logic [7:0] status3;
    logic dec_pend_n, irq;
    logic [15:0] blk_ptr, wr_addr;
    logic done, next_sec, same_sec;

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 0;

    logic [15:0] m_ptr = 16'h0000;
    logic [15:0] m_wa  = 16'h0000;
    logic [31:0] m_hdr = 32'h0100_0000;
    logic [7:0]  m_st3 = 8'h80;
    logic        m_pend = 1'b1;

    always #(CLK_P/2) clk = ~clk;

    sector_buf_writer dut (
        .clk(clk), .rst_n(rst_n), .dec_en(dec_en), .wr_en(wr_en), .dec_irq_en(dec_irq_en),
        .s_valid(s_valid), .s_sof(s_sof), .s_data(s_data), .s_ready(s_ready),
        .ptr_ld(ptr_ld), .wa_ld(wa_ld), .ld_data(ld_data), .st3_rd(st3_rd),
        .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .hdr_bank(hdr_bank), .status3(status3), .dec_pend_n(dec_pend_n), .irq(irq),
        .blk_ptr(blk_ptr), .wr_addr(wr_addr), .done(done), .next_sec(next_sec), .same_sec(same_sec)
    );

    function automatic logic [7:0] pat(input int s, input int k);
        return 8'((k * 7) ^ (s * 29) ^ (k >> 8));
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    endtask

    task automatic load_ptr(input logic [15:0] v);
        @(negedge clk); ptr_ld = 1; ld_data = v;
        @(negedge clk); ptr_ld = 0;
        #Q;
        chk("R11 blk_ptr load", 32'(blk_ptr), 32'(v));
        m_ptr = v;
    endtask

    task automatic load_wa(input logic [15:0] v);
        @(negedge clk); wa_ld = 1; ld_data = v;
        @(negedge clk); wa_ld = 0;
        #Q;
        chk("R11 wr_addr load", 32'(wr_addr), 32'(v));
        m_wa = v;
    endtask

    task automatic run_sector(input int s, input bit dec, input bit wr, input bit ie,
                              input bit toggle, input bit st3mid, input bit sofmid);
        bit exp_store;
        int base, nw, bad;
        @(negedge clk);
        dec_en = dec; wr_en = wr; dec_irq_en = ie;
        exp_store = dec && wr;
        if (exp_store) begin
            m_ptr = m_ptr + 16'd2352;
            m_wa  = m_wa + 16'd2352;
        end
        base = int'(m_ptr[13:0]);
        nw = 0; bad = 0;
        for (int k = 0; k < TOT; k++) begin
            if (k > 0) @(negedge clk);
            s_valid = 1;
            s_data  = pat(s, k);
            s_sof   = (k == 0) || (sofmid && k == 500);
            st3_rd  = st3mid && (k == 1000);
            if (toggle && k == 100) begin
                dec_en = !dec; wr_en = !wr;
            end
            #Q;
            if (!s_ready) bad++;
            if (mem_we) begin
                nw++;
                if (mem_addr !== 14'((base + k) % 16384) || mem_wdata !== pat(s, k)) bad++;
            end
        end
        @(negedge clk);
        s_valid = 0; s_sof = 0; st3_rd = 0;
        #Q;
        chk("R7 done pulse", 32'(done), 32'd1);
        chk("R7 next_sec", 32'(next_sec), 32'(exp_store));
        chk("R7 same_sec", 32'(same_sec), 32'(!exp_store));
        if (dec) begin
            m_hdr  = {pat(s, 3), pat(s, 2), pat(s, 1), pat(s, 0)};
            m_st3  = 8'h00;
            m_pend = 1'b0;
            if (st3mid) begin
                m_st3 = 8'h80; m_pend = 1'b1;
            end
        end
        chk(dec ? "R3 header bank" : "R2 header kept", hdr_bank, m_hdr);
        chk(st3mid ? "R8 status3 after read" : "R3 status3", 32'(status3), 32'(m_st3));
        chk("R3 dec_pend_n", 32'(dec_pend_n), 32'(m_pend));
        chk("R4 irq level", 32'(irq), 32'(ie && !m_pend));
        chk(exp_store ? "R5 blk_ptr step" : "R2 blk_ptr kept", 32'(blk_ptr), 32'(m_ptr));
        chk(exp_store ? "R5 wr_addr step" : "R2 wr_addr kept", 32'(wr_addr), 32'(m_wa));
        chk(toggle ? "R10 write count" : "R6 write count", nw, exp_store ? TOT : 0);
        chk(sofmid ? "R9 mid marker as data" : "R6 stored bytes", bad, 0);
        @(negedge clk);
        #Q;
        chk("R7 done single", 32'(done), 32'd0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired actual=running expected=finished");
        finish_run();
    end

    initial begin
        int bad;
        logic [15:0] starts [5];
        starts = '{16'h0000, 16'h1200, 16'h3000, 16'hF6D0, 16'h36C0};
        repeat (3) @(negedge clk);
        rst_n = 1;
        #Q;
        chk("R1 blk_ptr", 32'(blk_ptr), 0);
        chk("R1 wr_addr", 32'(wr_addr), 0);
        chk("R1 status3", 32'(status3), 32'h80);
        chk("R1 dec_pend_n", 32'(dec_pend_n), 1);
        chk("R1 irq", 32'(irq), 0);
        chk("R1 done", 32'(done), 0);
        chk("R1 s_ready", 32'(s_ready), 1);
        chk("R1 hdr_bank", hdr_bank, 32'h0100_0000);

        load_ptr(16'h0000);
        load_wa(16'h1000);

        run_sector(0, 0, 1, 1, 0, 0, 0);
        run_sector(1, 1, 0, 0, 0, 0, 0);

        @(negedge clk); dec_irq_en = 1;
        #Q;
        chk("R4 irq follows enable", 32'(irq), 1);
        @(negedge clk); st3_rd = 1;
        @(negedge clk); st3_rd = 0;
        #Q;
        chk("R8 status3 cleared", 32'(status3), 32'h80);
        chk("R8 pending cleared", 32'(dec_pend_n), 1);
        chk("R4 irq drops", 32'(irq), 0);
        m_st3 = 8'h80; m_pend = 1'b1;

        for (int i = 0; i < 5; i++) begin
            load_ptr(starts[i]);
            run_sector(10 + i, 1, 1, 1, 0, 0, 0);
        end
        run_sector(20, 1, 1, 1, 0, 0, 0);

        run_sector(21, 1, 1, 0, 1, 0, 0);
        run_sector(22, 0, 0, 0, 1, 0, 0);

        load_ptr(16'h3F00);
        run_sector(23, 1, 1, 1, 0, 1, 1);

        bad = 0;
        for (int k = 0; k < 5; k++) begin
            @(negedge clk);
            s_valid = 1; s_sof = 0; s_data = 8'(k + 3);
            dec_en = 1; wr_en = 1;
            #Q;
            if (mem_we || !s_ready || done) bad++;
        end
        @(negedge clk); s_valid = 0;
        #Q;
        chk("R9 idle bytes dropped", bad, 0);
        chk("R9 idle ptr kept", 32'(blk_ptr), 32'(m_ptr));
        chk("R9 idle header kept", hdr_bank, m_hdr);

        run_sector(24, 1, 1, 1, 0, 0, 0);

        finish_run();
    end

endmodule